// File: doc/BRIEF.md
# Interrupt Presentation Controller

A per-processor unit that holds the single interrupt currently presented to its CPU and drives one level-sensitive interrupt line. It keeps the processor's current priority, one pending source number with its priority, and a most-favored request priority that, when it beats the current priority, turns into an inter-processor interrupt (IPI) carrying a fixed source number.

Sources offer interrupts through a source-number plus priority input. An offer that cannot be presented is handed straight back on the reject output, and a pending source interrupt that loses its place to a better one is also handed back there. The CPU drives register-style commands: set current priority, set request priority, accept, end-of-interrupt (EOI) and poll. EOIs for real sources are forwarded on an EOI output, and whenever the processor lowers its priority barrier a resend request is strobed so sources can re-offer what they hold.

Lower numbers are more favored; priority 0xFF means "nothing pending" for the pending priority and "masked" for the request priority.

Top module: `irq_presenter`

## Requirements
- R1: After reset the presentation word reads 0x00000000 (current priority 0, no source), the pending priority and request priority are 0xFF, the interrupt output is low and no strobe is active.
- R2: The presentation word is {current priority in bits 31:24, pending source in bits 23:0}; source 0 means nothing is pending. Command codes on the 3-bit opcode are 0 set current priority, 1 set request priority, 2 accept, 3 EOI, 4 poll; other codes do nothing. Poll returns the presentation word one cycle later and changes no state.
- R3: An offer is refused when its priority is greater than or equal to the current priority, or when a source is pending whose priority is less than or equal to the offered one; a refused offer strobes the reject output with the offered source number.
- R4: An offer that is not refused is latched as the pending source and priority and raises the interrupt output; a displaced pending source interrupt is strobed on the reject output, a displaced IPI is not.
- R5: Setting the request priority (value in data bits 7:0) stores it; if the new value is below the current priority an IPI check runs: it is skipped when something is pending with priority less than or equal to the request value, otherwise any pending source is rejected, source number 2 is latched with the request value as pending priority, and the output rises.
- R6: Setting a more favored current priority (data bits 7:0) drops a pending interrupt when the new value is less than or equal to its priority: the source field clears, pending priority becomes 0xFF, the output falls and a dropped source is rejected.
- R7: Setting a less favored current priority strobes the resend output and runs the IPI check against the new current priority; an equal value does nothing else.
- R8: Accept returns the presentation word, lowers the output, moves the old pending priority into the current priority, clears the source field and sets the pending priority to 0xFF.
- R9: EOI loads the current priority from data bits 31:24, strobes the EOI output with data bits 23:0 unless they are 0 or the IPI number 2, then strobes resend and runs the IPI check against the new current priority.
- R10: Every command and offer completes in one clock: responses and strobes are valid for exactly the cycle after the edge that sampled the input; an offer must not coincide with a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | 32 | Command operand |
| rsp_valid_o | output | 1 | Response valid (accept, poll) |
| rsp_data_o | output | 32 | Response word |
| offer_valid_i | input | 1 | Source offers an interrupt |
| offer_src_i | input | 24 | Offered source number |
| offer_prio_i | input | 8 | Offered priority |
| reject_valid_o | output | 1 | Reject strobe |
| reject_src_o | output | 24 | Source number handed back |
| eoi_valid_o | output | 1 | EOI strobe toward sources |
| eoi_src_o | output | 24 | Source number completed |
| resend_o | output | 1 | Resend request strobe |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Every response, reject, EOI and resend strobe is due in the single cycle after the edge that samples the command or offer, and the interrupt level settles at that same edge. The bench drives each stimulus for one cycle, pushes the results it expects into a scoreboard queue in output order, and a monitor pops and compares whatever the block produces on the next falling edge; the driver then requires the queue to be empty before moving on, so a late, missing or extra strobe fails under R10. Scenarios cover refused and displacing offers, IPI creation and suppression, priority drops, accept and EOI with source, IPI and explicit priorities.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
  typedef enum logic [2:0] {
    OP_SET_CUR = 3'd0,
    OP_SET_REQ = 3'd1,
    OP_ACCEPT  = 3'd2,
    OP_EOI     = 3'd3,
    OP_POLL    = 3'd4
  } op_e;
endpackage

// File: rtl/irq_presenter_ipi_eval.sv
module irq_presenter_ipi_eval #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              chk_en_i,
  input  logic [PRIO_W-1:0] req_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic [SRC_W-1:0]  pend_src_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              pend_owned_i,
  output logic              fire_o,
  output logic              reject_o
);
  logic busy_better;

  always_comb begin
    busy_better = (pend_src_i != '0) && (pend_prio_i <= req_prio_i);
    fire_o      = chk_en_i && (req_prio_i < cur_prio_i) && !busy_better;
    reject_o    = fire_o && (pend_src_i != '0) && pend_owned_i;
  end
endmodule

// File: rtl/irq_presenter_offer_eval.sv
module irq_presenter_offer_eval #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              offer_en_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic [SRC_W-1:0]  pend_src_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              pend_owned_i,
  output logic              take_o,
  output logic              refuse_o,
  output logic              displace_o
);
  logic blocked;

  always_comb begin
    blocked    = (offer_prio_i >= cur_prio_i) ||
                 ((pend_src_i != '0) && (pend_prio_i <= offer_prio_i));
    refuse_o   = offer_en_i && blocked;
    take_o     = offer_en_i && !blocked;
    displace_o = take_o && (pend_src_i != '0) && pend_owned_i;
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter logic [SRC_W-1:0] IPI_SRC = 2,
  localparam int unsigned WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [WORD_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output logic              reject_valid_o,
  output logic [SRC_W-1:0]  reject_src_o,
  output logic              eoi_valid_o,
  output logic [SRC_W-1:0]  eoi_src_o,
  output logic              resend_o,
  output logic              irq_o
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  // architectural state
  logic [PRIO_W-1:0] cur_prio_q, cur_prio_d;
  logic [SRC_W-1:0]  pend_src_q, pend_src_d;
  logic [PRIO_W-1:0] pend_prio_q, pend_prio_d;
  logic [PRIO_W-1:0] req_prio_q, req_prio_d;
  logic              owned_q, owned_d;
  logic              irq_q, irq_d;

  // registered strobes
  logic              rsp_v_d, rej_v_d, eoi_v_d, resend_d;
  logic [WORD_W-1:0] rsp_d;
  logic [SRC_W-1:0]  rej_src_d, eoi_src_d;

  op_e               op;
  logic [PRIO_W-1:0] arg_prio, eoi_prio;
  logic [SRC_W-1:0]  eoi_src;
  logic              is_cur, is_req, is_acc, is_eoi, is_poll;
  logic              raise_cur, lower_cur;
  logic              ipi_en, ipi_fire, ipi_rej;
  logic [PRIO_W-1:0] ipi_req, ipi_cur;
  logic              off_take, off_refuse, off_displace;

  always_comb begin
    op        = op_e'(cmd_op_i);
    arg_prio  = cmd_data_i[PRIO_W-1:0];
    eoi_prio  = cmd_data_i[WORD_W-1:SRC_W];
    eoi_src   = cmd_data_i[SRC_W-1:0];
    is_cur    = cmd_valid_i && (op == OP_SET_CUR);
    is_req    = cmd_valid_i && (op == OP_SET_REQ);
    is_acc    = cmd_valid_i && (op == OP_ACCEPT);
    is_eoi    = cmd_valid_i && (op == OP_EOI);
    is_poll   = cmd_valid_i && (op == OP_POLL);
    lower_cur = is_cur && (arg_prio > cur_prio_q);
    raise_cur = is_cur && (arg_prio < cur_prio_q);
    ipi_en    = is_req || lower_cur || is_eoi;
    ipi_req   = is_req ? arg_prio : req_prio_q;
    ipi_cur   = is_cur ? arg_prio : (is_eoi ? eoi_prio : cur_prio_q);
  end

  irq_presenter_ipi_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) i_ipi_eval (
    .chk_en_i    (ipi_en),
    .req_prio_i  (ipi_req),
    .cur_prio_i  (ipi_cur),
    .pend_src_i  (pend_src_q),
    .pend_prio_i (pend_prio_q),
    .pend_owned_i(owned_q),
    .fire_o      (ipi_fire),
    .reject_o    (ipi_rej)
  );

  irq_presenter_offer_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) i_offer_eval (
    .offer_en_i  (offer_valid_i && !cmd_valid_i),
    .offer_prio_i(offer_prio_i),
    .cur_prio_i  (cur_prio_q),
    .pend_src_i  (pend_src_q),
    .pend_prio_i (pend_prio_q),
    .pend_owned_i(owned_q),
    .take_o      (off_take),
    .refuse_o    (off_refuse),
    .displace_o  (off_displace)
  );

  always_comb begin
    cur_prio_d  = cur_prio_q;
    pend_src_d  = pend_src_q;
    pend_prio_d = pend_prio_q;
    req_prio_d  = req_prio_q;
    owned_d     = owned_q;
    irq_d       = irq_q;
    rsp_v_d     = 1'b0;
    rsp_d       = '0;
    rej_v_d     = 1'b0;
    rej_src_d   = '0;
    eoi_v_d     = 1'b0;
    eoi_src_d   = '0;
    resend_d    = 1'b0;

    if (is_cur) begin
      cur_prio_d = arg_prio;
      if (raise_cur && (pend_src_q != '0) && (arg_prio <= pend_prio_q)) begin
        pend_src_d  = '0;
        pend_prio_d = PRIO_NONE;
        owned_d     = 1'b0;
        irq_d       = 1'b0;
        if (owned_q) begin
          rej_v_d   = 1'b1;
          rej_src_d = pend_src_q;
        end
      end
      resend_d = lower_cur;
    end
    if (is_req) req_prio_d = arg_prio;
    if (is_acc || is_poll) begin
      rsp_v_d = 1'b1;
      rsp_d   = {cur_prio_q, pend_src_q};
    end
    if (is_acc) begin
      cur_prio_d  = pend_prio_q;
      pend_src_d  = '0;
      pend_prio_d = PRIO_NONE;
      owned_d     = 1'b0;
      irq_d       = 1'b0;
    end
    if (is_eoi) begin
      cur_prio_d = eoi_prio;
      resend_d   = 1'b1;
      if ((eoi_src != '0) && (eoi_src != IPI_SRC)) begin
        eoi_v_d   = 1'b1;
        eoi_src_d = eoi_src;
      end
    end
    // IPI check shared by request write and both resend paths
    if (ipi_fire) begin
      if (ipi_rej) begin
        rej_v_d   = 1'b1;
        rej_src_d = pend_src_q;
      end
      pend_src_d  = IPI_SRC;
      pend_prio_d = ipi_req;
      owned_d     = 1'b0;
      irq_d       = 1'b1;
    end
    if (off_refuse) begin
      rej_v_d   = 1'b1;
      rej_src_d = offer_src_i;
    end
    if (off_take) begin
      if (off_displace) begin
        rej_v_d   = 1'b1;
        rej_src_d = pend_src_q;
      end
      pend_src_d  = offer_src_i;
      pend_prio_d = offer_prio_i;
      owned_d     = 1'b1;
      irq_d       = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_prio_q     <= '0;
      pend_src_q     <= '0;
      pend_prio_q    <= PRIO_NONE;
      req_prio_q     <= PRIO_NONE;
      owned_q        <= 1'b0;
      irq_q          <= 1'b0;
      rsp_valid_o    <= 1'b0;
      rsp_data_o     <= '0;
      reject_valid_o <= 1'b0;
      reject_src_o   <= '0;
      eoi_valid_o    <= 1'b0;
      eoi_src_o      <= '0;
      resend_o       <= 1'b0;
    end else begin
      cur_prio_q     <= cur_prio_d;
      pend_src_q     <= pend_src_d;
      pend_prio_q    <= pend_prio_d;
      req_prio_q     <= req_prio_d;
      owned_q        <= owned_d;
      irq_q          <= irq_d;
      rsp_valid_o    <= rsp_v_d;
      rsp_data_o     <= rsp_d;
      reject_valid_o <= rej_v_d;
      reject_src_o   <= rej_src_d;
      eoi_valid_o    <= eoi_v_d;
      eoi_src_o      <= eoi_src_d;
      resend_o       <= resend_d;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_TRACKS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend_src_q != '0)); // R4
  AST_IDLE_PRIO_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_src_q == '0) |-> (pend_prio_q == PRIO_NONE)); // R8
  AST_REFUSE_WORSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_valid_i && !cmd_valid_i && (offer_prio_i >= cur_prio_q))
    |=> (reject_valid_o && (reject_src_o == $past(offer_src_i)))); // R3
  AST_ACCEPT_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 3'd2)) |=> (!irq_o && rsp_valid_o)); // R8
  AST_EOI_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 3'd3) && (cmd_data_i[SRC_W-1:0] != '0) &&
     (cmd_data_i[SRC_W-1:0] != IPI_SRC))
    |=> (eoi_valid_o && resend_o && (eoi_src_o == $past(cmd_data_i[SRC_W-1:0])))); // R9
  AST_RESEND_ON_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 3'd0) && (cmd_data_i[PRIO_W-1:0] > cur_prio_q))
    |=> resend_o); // R7
  AST_OFFER_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && offer_valid_i)); // R10
endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        reject_valid;
  logic [23:0] reject_src;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    int          kind; // 0 response, 1 reject, 2 eoi, 3 resend
    logic [31:0] val;
    string       tag;
  } ev_t;
  ev_t exp_q[$];

  always #10 clk = ~clk; // 50 MHz

  irq_presenter i_irq_presenter (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .offer_valid_i(offer_valid), .offer_src_i(offer_src), .offer_prio_i(offer_prio),
    .reject_valid_o(reject_valid), .reject_src_o(reject_src),
    .eoi_valid_o(eoi_valid), .eoi_src_o(eoi_src),
    .resend_o(resend), .irq_o(irq)
  );

  task automatic expect_ev(input int kind, input logic [31:0] val, input string tag);
    ev_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [31:0] val);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected event kind=%0d actual=%h expected=none", kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val != val) begin
        errors++;
        $display("FAIL %s kind actual=%0d expected=%0d value actual=%h expected=%h",
                 e.tag, kind, e.kind, val, e.val);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid)    observe(0, rsp_data);
      if (reject_valid) observe(1, {8'h0, reject_src});
      if (eoi_valid)    observe(2, {8'h0, eoi_src});
      if (resend)       observe(3, 32'h0);
    end
  end

  task automatic settle(input logic exp_irq, input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 %s missing events actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] data,
                        input logic exp_irq, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
    settle(exp_irq, tag);
  endtask

  task automatic do_offer(input logic [23:0] src, input logic [7:0] prio,
                          input logic exp_irq, input string tag);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = src; offer_prio = prio;
    @(negedge clk);
    #1;
    offer_valid = 1'b0;
    settle(exp_irq, tag);
  endtask

  task automatic poll(input logic [31:0] word, input logic exp_irq, input string tag);
    expect_ev(0, word, tag);
    do_cmd(3'd4, 32'h0, exp_irq, tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== 1'b0 || reject_valid !== 1'b0 || resend !== 1'b0 || rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset actual=%b%b%b%b expected=0000",
               irq, reject_valid, resend, rsp_valid);
    end
    rst_n = 1'b1;
    poll(32'h0000_0000, 1'b0, "R1 reset word");

    // current priority 0 after reset: every offer refused
    expect_ev(1, 32'h10, "R3 refuse at prio 0");
    do_offer(24'h10, 8'd5, 1'b0, "R3 refuse at prio 0");

    expect_ev(3, 0, "R7 lower to FF resends");
    do_cmd(3'd0, 32'hFF, 1'b0, "R7 lower to FF");

    do_offer(24'h10, 8'd5, 1'b1, "R4 take first");
    poll(32'hFF00_0010, 1'b1, "R2 poll layout");

    expect_ev(1, 32'h20, "R3 equal pending prio refused");
    do_offer(24'h20, 8'd5, 1'b1, "R3 equal pending prio");

    expect_ev(1, 32'h10, "R4 displaced source rejected");
    do_offer(24'h30, 8'd3, 1'b1, "R4 displace");
    poll(32'hFF00_0030, 1'b1, "R4 new pending");

    do_cmd(3'd1, 32'h04, 1'b1, "R5 IPI skipped");
    poll(32'hFF00_0030, 1'b1, "R5 pending kept");

    expect_ev(1, 32'h30, "R5 IPI rejects source");
    do_cmd(3'd1, 32'h01, 1'b1, "R5 IPI fires");
    poll(32'hFF00_0002, 1'b1, "R5 IPI number 2");

    do_offer(24'h40, 8'd0, 1'b1, "R4 IPI displaced silently");
    poll(32'hFF00_0040, 1'b1, "R4 after IPI displaced");

    expect_ev(0, 32'hFF00_0040, "R8 accept word");
    do_cmd(3'd2, 32'h0, 1'b0, "R8 accept");
    poll(32'h0000_0000, 1'b0, "R8 cur prio from pending");

    expect_ev(2, 32'h40, "R9 EOI forwarded");
    expect_ev(3, 0, "R9 EOI resend");
    do_cmd(3'd3, 32'hFF00_0040, 1'b1, "R9 EOI source, IPI recreated");
    poll(32'hFF00_0002, 1'b1, "R9 IPI after EOI");

    expect_ev(0, 32'hFF00_0002, "R8 accept IPI");
    do_cmd(3'd2, 32'h0, 1'b0, "R8 accept IPI");

    expect_ev(3, 0, "R9 EOI of IPI not forwarded");
    do_cmd(3'd3, 32'hFF00_0002, 1'b1, "R9 EOI IPI");

    do_cmd(3'd1, 32'hFF, 1'b1, "R5 mask request");
    expect_ev(0, 32'hFF00_0002, "R8 accept");
    do_cmd(3'd2, 32'h0, 1'b0, "R8 accept again");

    expect_ev(3, 0, "R9 EOI prio 5 resend");
    do_cmd(3'd3, 32'h0500_0002, 1'b0, "R9 EOI prio 5");
    poll(32'h0500_0000, 1'b0, "R9 prio from EOI");

    do_offer(24'h50, 8'd4, 1'b1, "R4 take under 5");
    expect_ev(1, 32'h50, "R6 drop rejects");
    do_cmd(3'd0, 32'h04, 1'b0, "R6 drop on raise");
    poll(32'h0400_0000, 1'b0, "R6 cleared");

    do_offer(24'h60, 8'd2, 1'b1, "R4 take prio 2");
    do_cmd(3'd0, 32'h03, 1'b1, "R6 no drop");
    poll(32'h0300_0060, 1'b1, "R6 kept");

    do_cmd(3'd0, 32'h03, 1'b1, "R7 equal priority idle");
    do_cmd(3'd7, 32'hFFFF_FFFF, 1'b1, "R2 unused code ignored");
    poll(32'h0300_0060, 1'b1, "R2 state unchanged");

    expect_ev(3, 0, "R7 lower resends");
    do_cmd(3'd0, 32'h10, 1'b1, "R7 lower to 10");
    poll(32'h1000_0060, 1'b1, "R7 word after lower");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 leftover actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule